// File: doc/BRIEF.md
# Dual-Role Serial Peripheral Interface Controller

This block is a byte-oriented SPI controller behind a small register bus. One system clock runs all of it. Software sets it up as master or slave through a control register. As master, a write to the data register sends the byte at once on an SCK made by dividing the system clock. A completion flag in the status register then tells polling software that the byte has gone out and that the received byte can be read.

As slave, the block does not run on the incoming SCK. It passes SCK, MOSI and the select line through synchronizers, finds the SCK edges with system-clock logic, and shifts on those edges. For this reason each SCK phase must last at least three system clock cycles.

The block also drives the output enables of the four pads. The input side of the chosen role is forced, and the other pads keep the direction that software chose for them.

Top module: `spi_dual_role`

## Requirements
- R1: After reset the control, status and data registers read 0 and sck_out is low. Register addresses: 0 is control, 1 is status, 2 is data. Control bit 7 enables the block, bit 6 selects master, and bits 1:0 select the rate. Status bit 7 is the completion flag and bit 6 is the collision bit.
- R2: In master mode a data-register write starts the transfer at once, MSB first, in mode 0. mosi_out holds the MSB right after the write, changes only when SCK falls, and at every rising SCK edge it carries the next bit of the byte.
- R3: The master SCK half period is div/2 system cycles. Rate codes 0, 1, 2 and 3 give div values of 4, 16, 64 and 128. The completion flag becomes visible exactly 8*div cycles after the write edge, and SCK is low whenever no transfer is running.
- R4: The completion flag, status bit 7, is set when the eighth bit completes, in both roles.
- R5: The master samples miso_in on each rising SCK edge. After completion the data register reads the received byte, MSB first.
- R6: The flag and the collision bit are cleared by a status read made while either of them is set, followed by any data-register access. A data access with no such status read first leaves them set.
- R7: A data write while a master transfer is in progress is ignored and sets the collision bit, status bit 6. The transfer continues with the original byte.
- R8: In slave mode, sck_in and mosi_in pass through a two-flop synchronizer. mosi is captured on a synchronized rising SCK edge and shifted on a falling one. miso_out shows the preloaded byte MSB first. The flag is set after the eighth falling edge, and SCK phases of 3 or more system cycles are handled.
- R9: In slave mode, while the synchronized select is high, the bit counter is held at zero and miso_oe is 0, so a partial byte is discarded.
- R10: In master mode, miso_oe is 0, and mosi_oe, sck_oe and ss_oe follow their direction inputs.
- R11: In slave mode, mosi_oe, sck_oe and ss_oe are 0, and miso_oe follows dir_miso while the select is low.
- R12: When disabled, every output enable follows its direction input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| sck_in | input | 1 | Serial clock from pad |
| sck_out | output | 1 | Serial clock to pad |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_in | input | 1 | Master-out line from pad |
| mosi_out | output | 1 | Master-out line to pad |
| mosi_oe | output | 1 | Master-out output enable |
| miso_in | input | 1 | Master-in line from pad |
| miso_out | output | 1 | Master-in line to pad |
| miso_oe | output | 1 | Master-in output enable |
| ss_in | input | 1 | Active-low select from pad |
| ss_oe | output | 1 | Select pad output enable |
| dir_sck | input | 1 | Software direction for SCK pad |
| dir_mosi | input | 1 | Software direction for master-out pad |
| dir_miso | input | 1 | Software direction for master-in pad |
| dir_ss | input | 1 | Software direction for select pad |

## Verification
The bench builds the block with its defaults: DATA_W of 8, two synchronizer stages and a 7-bit half-period counter. With these values all four rate codes can be reached, up to the 64-cycle half period of div 128, so the exact 8*div completion count is checked at every rate. The slave is driven with 4-cycle SCK phases, which sits just above the 3-cycle limit. The bench also aborts a slave byte with the select line to show that the counter restarts.

// File: rtl/spi_dr_pkg.sv
package spi_dr_pkg;
  localparam int HALF_W = 7;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam int CTRL_EN  = 7;
  localparam int CTRL_MST = 6;

  typedef enum logic [1:0] {RATE_4, RATE_16, RATE_64, RATE_128} rate_e;

  // half period of master SCK in system cycles
  function automatic logic [HALF_W-1:0] half_of(input rate_e r);
    case (r)
      RATE_4:  half_of = HALF_W'(2);
      RATE_16: half_of = HALF_W'(8);
      RATE_64: half_of = HALF_W'(32);
      default: half_of = HALF_W'(64);
    endcase
  endfunction
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int HALF_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              tick
);
  logic [HALF_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q >= half - HALF_W'(1));
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + HALF_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: counter rests at zero while idle
  a_r3_div_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> cnt_q == '0);
endmodule

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= RST_VAL;
        else        stg_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= RST_VAL;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/spi_pin_dir.sv
module spi_pin_dir (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic master,
  input  logic sel_n,
  input  logic dir_sck,
  input  logic dir_mosi,
  input  logic dir_miso,
  input  logic dir_ss,
  output logic sck_oe,
  output logic mosi_oe,
  output logic miso_oe,
  output logic ss_oe
);
  always_comb begin
    sck_oe  = dir_sck;
    mosi_oe = dir_mosi;
    miso_oe = dir_miso;
    ss_oe   = dir_ss;
    if (en && master) begin
      miso_oe = 1'b0;
    end else if (en) begin
      sck_oe  = 1'b0;
      mosi_oe = 1'b0;
      ss_oe   = 1'b0;
      miso_oe = dir_miso && !sel_n;
    end
  end

  a_r10_master_miso_in: assert property (@(posedge clk) disable iff (!rst_n)
    (en && master) |-> (!miso_oe && sck_oe == dir_sck && mosi_oe == dir_mosi));
  a_r11_slave_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !master) |-> (!sck_oe && !mosi_oe && !ss_oe));
  a_r9_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !master && sel_n) |-> !miso_oe);
  a_r12_off_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (miso_oe == dir_miso && ss_oe == dir_ss));
endmodule

// File: rtl/spi_dual_role.sv
module spi_dual_role
  import spi_dr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  input  logic              mosi_in,
  output logic              mosi_out,
  output logic              mosi_oe,
  input  logic              miso_in,
  output logic              miso_out,
  output logic              miso_oe,
  input  logic              ss_in,
  output logic              ss_oe,
  input  logic              dir_sck,
  input  logic              dir_mosi,
  input  logic              dir_miso,
  input  logic              dir_ss
);
  localparam int BCW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BCW-1:0] LAST_BIT = BCW'(DATA_W - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  logic [DATA_W-1:0] ctrl_q, ctrl_d, sh_q, sh_d;
  logic [BCW-1:0]    cnt_q, cnt_d;
  logic busy_q, busy_d, sck_q, sck_d, rx_q, rx_d;
  logic flag_q, flag_d, wcol_q, wcol_d, arm_q, arm_d, sckp_q;

  logic en, master_mode, slave_mode, tick;
  logic ctrl_wr, data_wr, data_acc, stat_rd, start, coll, clr;
  logic sck_s, mosi_s, ss_s, s_rise, s_fall, m_rise, m_fall;
  logic rise_evt, fall_evt, last;

  spi_in_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_ni), .d({ss_in, mosi_in, sck_in}),
    .q({ss_s, mosi_s, sck_s}));

  spi_clk_div #(.HALF_W(HALF_W)) u_div (
    .clk(clk), .rst_n(rst_ni), .run(busy_q),
    .half(half_of(rate_e'(ctrl_q[1:0]))), .tick(tick));

  spi_pin_dir u_dir (
    .clk(clk), .rst_n(rst_ni), .en(en), .master(ctrl_q[CTRL_MST]), .sel_n(ss_s),
    .dir_sck(dir_sck), .dir_mosi(dir_mosi), .dir_miso(dir_miso), .dir_ss(dir_ss),
    .sck_oe(sck_oe), .mosi_oe(mosi_oe), .miso_oe(miso_oe), .ss_oe(ss_oe));

  always_comb begin
    en          = ctrl_q[CTRL_EN];
    master_mode = en && ctrl_q[CTRL_MST];
    slave_mode  = en && !ctrl_q[CTRL_MST];
    ctrl_wr     = bus_sel && bus_we && bus_addr == A_CTRL;
    data_wr     = bus_sel && bus_we && bus_addr == A_DATA;
    data_acc    = bus_sel && bus_addr == A_DATA;
    stat_rd     = bus_sel && !bus_we && bus_addr == A_STAT;
    start       = data_wr && master_mode && !busy_q;
    coll        = data_wr && master_mode && busy_q;
    clr         = data_acc && arm_q;
    s_rise      = slave_mode && !ss_s && sck_s && !sckp_q;
    s_fall      = slave_mode && !ss_s && !sck_s && sckp_q;
    m_rise      = busy_q && tick && !sck_q;
    m_fall      = busy_q && tick && sck_q;
    rise_evt    = m_rise || s_rise;
    fall_evt    = m_fall || s_fall;
    last        = fall_evt && cnt_q == LAST_BIT;
  end

  // next state
  always_comb begin
    ctrl_d = ctrl_wr ? bus_wdata : ctrl_q;
    sh_d   = sh_q;
    if (data_wr && !busy_q) sh_d = bus_wdata;
    else if (fall_evt)      sh_d = {sh_q[DATA_W-2:0], rx_q};
    rx_d = rise_evt ? (master_mode ? miso_in : mosi_s) : rx_q;
    cnt_d = cnt_q;
    if (start || !en || (slave_mode && ss_s)) cnt_d = '0;
    else if (fall_evt) cnt_d = last ? '0 : cnt_q + BCW'(1);
    busy_d = busy_q;
    if (!master_mode)          busy_d = 1'b0;
    else if (start)            busy_d = 1'b1;
    else if (m_fall && last)   busy_d = 1'b0;
    sck_d  = (busy_q && tick) ? !sck_q : sck_q;
    if (!master_mode) sck_d = 1'b0;
    flag_d = last ? 1'b1 : (clr ? 1'b0 : flag_q);
    wcol_d = coll ? 1'b1 : (clr ? 1'b0 : wcol_q);
    arm_d  = stat_rd ? (flag_q || wcol_q) : (data_acc ? 1'b0 : arm_q);
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0; sh_q <= '0; cnt_q <= '0; busy_q <= 1'b0; sck_q <= 1'b0;
      rx_q <= 1'b0; flag_q <= 1'b0; wcol_q <= 1'b0; arm_q <= 1'b0; sckp_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d; sh_q <= sh_d; cnt_q <= cnt_d; busy_q <= busy_d;
      sck_q <= sck_d; rx_q <= rx_d; flag_q <= flag_d; wcol_q <= wcol_d;
      arm_q <= arm_d; sckp_q <= sck_s;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_q;
      A_STAT:  bus_rdata = {flag_q, wcol_q, {(DATA_W-2){1'b0}}};
      A_DATA:  bus_rdata = sh_q;
      default: bus_rdata = '0;
    endcase
    sck_out  = sck_q;
    mosi_out = master_mode && sh_q[DATA_W-1];
    miso_out = sh_q[DATA_W-1];
  end

  a_r2_mosi_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_q && $rose(sck_q)) |-> $stable(mosi_out));
  a_r3_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy_q |-> !sck_out);
  a_r4_flag_at_end: assert property (@(posedge clk) disable iff (!rst_ni)
    (master_mode && $past(master_mode) && $fell(busy_q)) |-> flag_q);
  a_r7_collision_mark: assert property (@(posedge clk) disable iff (!rst_ni)
    (coll && !clr) |=> wcol_q);
  a_r9_count_held: assert property (@(posedge clk) disable iff (!rst_ni)
    (slave_mode && ss_s) |=> cnt_q == '0);
endmodule

// File: tb/tb_spi_dual_role.sv
module tb_spi_dual_role;
  localparam int DW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_we = 0;
  logic [1:0] bus_addr = 0;
  logic [DW-1:0] bus_wdata = 0, bus_rdata;
  logic sck_in = 0, mosi_in = 0, miso_in = 0, ss_in = 1;
  logic sck_out, sck_oe, mosi_out, mosi_oe, miso_out, miso_oe, ss_oe;
  logic dir_sck = 0, dir_mosi = 1, dir_miso = 0, dir_ss = 1;
  int tests = 0, fails = 0;
  bit done = 0;

  spi_dual_role dut (.*);

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  function automatic int div_of(input logic [1:0] r);
    return (r == 0) ? 4 : (r == 1) ? 16 : (r == 2) ? 64 : 128;
  endfunction

  task automatic bus_write(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [DW-1:0] d);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic master_xfer(input logic [7:0] tx, input logic [7:0] rx,
                             input logic [1:0] rate, input bit collide);
    int cyc = 0, bi = 0, bad = 0;
    logic prev = 0;
    logic [7:0] st, d;
    bus_write(2'd0, {2'b11, 4'b0, rate});
    miso_in = rx[7];
    bus_write(2'd2, tx);
    check("R2 mosi MSB after write", mosi_out, tx[7]);
    if (collide) begin
      bus_write(2'd2, ~tx);
      cyc = 2;
      prev = sck_out;
    end
    bus_addr = 2'd1;
    while (cyc < 3000) begin
      @(posedge clk); #1; cyc++;
      if (sck_out && !prev && mosi_out !== tx[7-bi]) bad++;
      if (!sck_out && prev) begin bi++; if (bi < 8) miso_in = rx[7-bi]; end
      prev = sck_out;
      if (bus_rdata[7]) break;
    end
    if (!collide) check("R3 completion cycles", cyc, 8*div_of(rate));
    check("R2 mosi bits at rising edges", bad, 0);
    check("R4 flag set", bus_rdata[7], 1);
    if (collide) check("R7 collision bit", bus_rdata[6], 1);
    check("R3 sck low after transfer", sck_out, 0);
    bus_read(2'd1, st);
    bus_read(2'd2, d);
    check("R5 received byte", d, rx);
    peek(2'd1, st);
    check("R6 flag and collision cleared", st, 8'h00);
  endtask

  task automatic slave_bits(input logic [7:0] m, input logic [7:0] exp_miso,
                            input int nbits, inout int bad);
    for (int i = 0; i < nbits; i++) begin
      mosi_in = m[7-i];
      repeat (4) @(negedge clk);
      if (miso_out !== exp_miso[7-i]) bad++;
      sck_in = 1;
      repeat (4) @(negedge clk);
      sck_in = 0;
    end
  endtask

  initial begin
    logic [7:0] v, st;
    int bad;
    void'($urandom(32'h5EED0042));
    dir_sck = 1; dir_mosi = 0; dir_miso = 1; dir_ss = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    peek(2'd0, v); check("R1 control reset", v, 0);
    peek(2'd1, v); check("R1 status reset", v, 0);
    peek(2'd2, v); check("R1 data reset", v, 0);
    check("R1 sck low", sck_out, 0);
    check("R12 disabled oe follow dir", {sck_oe, mosi_oe, miso_oe, ss_oe}, 4'b1010);

    // master: every rate, then random
    for (int r = 0; r < 4; r++) begin
      dir_sck = $urandom; dir_mosi = $urandom; dir_ss = $urandom; dir_miso = 1;
      master_xfer(8'($urandom), 8'($urandom), 2'(r), 0);
      check("R10 master oe", {sck_oe, mosi_oe, miso_oe, ss_oe},
            {dir_sck, dir_mosi, 1'b0, dir_ss});
    end
    for (int k = 0; k < 3; k++) master_xfer(8'($urandom), 8'($urandom), 2'($urandom), 0);
    master_xfer(8'hA5, 8'h3C, 2'd0, 0);
    master_xfer(8'h00, 8'hFF, 2'd0, 1);

    // R6: data access without the status read leaves the flag
    master_xfer(8'h81, 8'h7E, 2'd0, 0);
    bus_write(2'd2, 8'h55);
    bus_addr = 2'd1; miso_in = 0;
    repeat (40) @(negedge clk);
    bus_read(2'd2, v);
    peek(2'd1, st);
    check("R6 flag kept without status read", st[7], 1);
    bus_read(2'd1, st); bus_read(2'd2, v);
    peek(2'd1, st);
    check("R6 flag cleared after sequence", st[7], 0);

    // slave
    dir_miso = 1; dir_sck = 1; dir_mosi = 1; dir_ss = 1;
    bus_write(2'd0, 8'h80);
    bus_write(2'd2, 8'hC3);
    repeat (4) @(negedge clk);
    check("R9 miso off while deselected", miso_oe, 0);
    check("R11 slave oe", {sck_oe, mosi_oe, ss_oe}, 3'b000);
    ss_in = 0; repeat (4) @(negedge clk);
    check("R11 miso oe follows dir", miso_oe, 1);
    bad = 0;
    slave_bits(8'h5A, 8'hC3, 8, bad);
    repeat (6) @(negedge clk);
    check("R8 slave miso bits", bad, 0);
    peek(2'd1, st); check("R8 slave flag", st[7], 1);
    bus_read(2'd1, st); bus_read(2'd2, v);
    check("R8 slave received byte", v, 8'h5A);
    for (int k = 0; k < 2; k++) begin
      logic [7:0] m, t;
      m = 8'($urandom); t = 8'($urandom);
      ss_in = 1; repeat (4) @(negedge clk);
      bus_write(2'd2, t);
      ss_in = 0; repeat (4) @(negedge clk);
      bad = 0;
      slave_bits(m, t, 8, bad);
      repeat (6) @(negedge clk);
      check("R8 random slave miso", bad, 0);
      bus_read(2'd1, st); bus_read(2'd2, v);
      check("R8 random slave rx", v, m);
    end
    // R9: aborted byte restarts the count
    bad = 0;
    slave_bits(8'hE0, 8'h00, 3, bad);
    ss_in = 1; repeat (5) @(negedge clk);
    peek(2'd1, st); check("R9 no flag after abort", st[7], 0);
    ss_in = 0; repeat (4) @(negedge clk);
    slave_bits(8'h96, 8'h00, 5, bad);
    repeat (6) @(negedge clk);
    peek(2'd1, st); check("R9 no flag at 8 total edges", st[7], 0);
    slave_bits(8'h96 << 5, 8'h00, 3, bad);
    repeat (6) @(negedge clk);
    peek(2'd1, st); check("R9 flag after full byte", st[7], 1);
    peek(2'd2, v); check("R9 byte after restart", v, 8'h96);

    bus_write(2'd0, 8'h00);
    dir_sck = 0; dir_mosi = 1; dir_miso = 1; dir_ss = 0;
    #1 check("R12 disabled oe", {sck_oe, mosi_oe, miso_oe, ss_oe}, 4'b0110);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule